// File: doc/BRIEF.md
# Raw Receive Serial Port: Data Gating and Event Line

This block drives the receive side of a radio's raw serial port: the mode in which packet handling is bypassed and the host's synchronous serial interface takes demodulated bits directly. It takes the demodulator's recovered bit stream, a one-cycle bit clock enable, and the preamble-detect and sync-detect pulses. From these it produces three outputs. The first is a receive bit clock that runs only while the radio is in its receive state and raw mode is selected. The second is a receive data line that opens either at once or from the preamble, depending on a pin-configuration code. The third is an event line that gives either a sticky interrupt level or a byte strobe.

The byte strobe is phase-locked to the trigger pulse. When the trigger is sync detection, the strobe marks the first bit of every byte that follows the sync word, so the host gets byte alignment without parsing the frame. The 8-bit configuration code picks the data-gating rule, the trigger source and the event kind. A 2-bit data-mode field turns raw mode on or off.

Each input bit is qualified by `bit_en`. The block registers that bit and the event state on that edge and holds them until the next enabled bit. Leaving the receive state clears all state.

Top module: `rawrx_port`

## Requirements
- R1: Raw mode is on only when `data_mode` is 1 or 2. With `data_mode` equal to 0 or 3, `rx_clk_o`, `rx_data_o` and `evt_o` stay low even while `rx_state` is high.
- R2: `rx_clk_o` equals `bit_en` in the same cycle whenever `rx_state` is high and raw mode is on. Otherwise it is low.
- R3: With code 0xA0, 0xA3 or 0xA6, every enabled bit appears on `rx_data_o` from the first bit in the receive state. It appears in the cycle after its `bit_en` edge and holds until the next enabled bit.
- R4: With code 0xA1, 0xA2, 0xA4, 0xA5, 0xA7 or 0xA8, `rx_data_o` stays low until the bit that carries `pre_det`. That bit and every later bit are then passed.
- R5: The code selects the event behaviour as follows:
  - 0xA0: no event.
  - 0xA1 and 0xA7: interrupt on preamble.
  - 0xA2: strobe on preamble.
  - 0xA3 and 0xA4: interrupt on sync.
  - 0xA5, 0xA6 and 0xA8: strobe on sync.
- R6: In interrupt kind, `evt_o` rises in the cycle after the edge of the bit that carries the trigger pulse. It stays high for as long as the receive state persists.
- R7: In strobe kind, `evt_o` is high during the first bit after the trigger bit. It is high for exactly one bit period and repeats every 8 enabled bits.
- R8: A new trigger pulse while armed restarts the byte count. The next strobe marks the bit that follows the new trigger.
- R9: When `rx_state` falls or raw mode turns off, `rx_data_o` and `evt_o` are low from the next cycle. On re-entry the data gate is closed again and the event line is disarmed.
- R10: A code outside the listed set keeps `rx_data_o` and `evt_o` low, whatever the detect pulses do.
- R11: Synchronous active-high `rst` drives `rx_data_o` and `evt_o` low in the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle enable per recovered bit |
| rx_bit | input | 1 | Recovered bit value, valid with `bit_en` |
| pre_det | input | 1 | Preamble-detect pulse, valid with `bit_en` |
| sync_det | input | 1 | Sync-word-detect pulse on the last sync bit, valid with `bit_en` |
| rx_state | input | 1 | High while the radio is in its raw receive state |
| data_mode | input | 2 | 0: packet-managed; 1 or 2: raw serial mode; 3: off |
| pin_cfg | input | 8 | Pin-configuration code selecting gating and event behaviour |
| rx_clk_o | output | 1 | Receive bit clock toward the host |
| rx_data_o | output | 1 | Gated receive data toward the host |
| evt_o | output | 1 | Interrupt level or byte strobe |

## Verification
The bench feeds short bit streams under each gating rule. An immediate code must show the very first bit. A preamble code must hide bits until the detect pulse and then show the pulse's own bit. Strobe runs are long enough to reach the second strobe eight bits later, which separates a correct modulo-8 count from an off-by-one. A second sync pulse in mid-byte shows whether the count realigns. Interrupt runs carry a pulse of the source that is not selected, and runs in disabled modes and with an unknown code carry every pulse; the outputs must stay quiet in both cases.

// File: rtl/rawrx_pkg.sv
package rawrx_pkg;

    localparam int unsigned BYTE_BITS = 8;

    typedef enum logic [1:0] {
        GATE_OFF = 2'd0,
        GATE_IMM = 2'd1,
        GATE_PRE = 2'd2
    } gate_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PRE  = 2'd1,
        SRC_SYNC = 2'd2
    } src_e;

    typedef enum logic {
        KIND_IRQ    = 1'b0,
        KIND_STROBE = 1'b1
    } kind_e;

    typedef struct packed {
        gate_e gate;
        src_e  src;
        kind_e kind;
    } pincfg_t;

    function automatic pincfg_t decode_pincfg(input logic [7:0] code);
        pincfg_t c;
        c = '{gate: GATE_OFF, src: SRC_NONE, kind: KIND_IRQ};
        case (code)
            8'hA0: c = '{gate: GATE_IMM, src: SRC_NONE, kind: KIND_IRQ};
            8'hA1: c = '{gate: GATE_PRE, src: SRC_PRE,  kind: KIND_IRQ};
            8'hA2: c = '{gate: GATE_PRE, src: SRC_PRE,  kind: KIND_STROBE};
            8'hA3: c = '{gate: GATE_IMM, src: SRC_SYNC, kind: KIND_IRQ};
            8'hA4: c = '{gate: GATE_PRE, src: SRC_SYNC, kind: KIND_IRQ};
            8'hA5: c = '{gate: GATE_PRE, src: SRC_SYNC, kind: KIND_STROBE};
            8'hA6: c = '{gate: GATE_IMM, src: SRC_SYNC, kind: KIND_STROBE};
            8'hA7: c = '{gate: GATE_PRE, src: SRC_PRE,  kind: KIND_IRQ};
            8'hA8: c = '{gate: GATE_PRE, src: SRC_SYNC, kind: KIND_STROBE};
            default: c = '{gate: GATE_OFF, src: SRC_NONE, kind: KIND_IRQ};
        endcase
        return c;
    endfunction

    function automatic logic mode_is_raw(input logic [1:0] m);
        return (m == 2'd1) || (m == 2'd2);
    endfunction

endpackage

// File: rtl/rawrx_data_gate.sv
module rawrx_data_gate
    import rawrx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  bit_en,
    input  gate_e rule,
    input  logic  pre_det,
    input  logic  rx_bit,
    output logic  rx_data
);

    logic gate_q;
    logic bit_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            gate_q <= 1'b0;
            bit_q  <= 1'b0;
        end else if (bit_en) begin
            gate_q <= gate_q || (rule == GATE_IMM) || ((rule == GATE_PRE) && pre_det);
            bit_q  <= rx_bit;
        end
    end

    assign rx_data = gate_q & bit_q;

    // R9: leaving the receive state closes the gate
    a_r9_gate_clear: assert property (@(posedge clk) disable iff (rst)
        !active |=> !gate_q);

    // R4: once open the gate stays open during the receive state
    a_r4_gate_sticky: assert property (@(posedge clk) disable iff (rst)
        (gate_q && active) |=> gate_q);

    // R4: a preamble rule opens only on a qualified preamble pulse
    a_r4_pre_hold: assert property (@(posedge clk) disable iff (rst)
        ((rule == GATE_PRE) && !gate_q && !(bit_en && pre_det)) |=> !gate_q);

    // R10: an unknown code never opens the gate
    a_r10_gate_shut: assert property (@(posedge clk) disable iff (rst)
        ((rule == GATE_OFF) && !gate_q) |=> !gate_q);

endmodule

// File: rtl/rawrx_event_gen.sv
module rawrx_event_gen
    import rawrx_pkg::*;
#(
    parameter int unsigned BITS_PER_BYTE = BYTE_BITS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  bit_en,
    input  logic  pre_det,
    input  logic  sync_det,
    input  src_e  src,
    input  kind_e kind,
    output logic  evt
);

    localparam int unsigned CNT_W = (BITS_PER_BYTE > 1) ? $clog2(BITS_PER_BYTE) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BITS_PER_BYTE - 1);

    logic             irq_q;
    logic             strb_q;
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             trig;

    assign trig = bit_en && (((src == SRC_PRE) && pre_det) ||
                             ((src == SRC_SYNC) && sync_det));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            irq_q   <= 1'b0;
            strb_q  <= 1'b0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (trig) begin
            irq_q   <= 1'b1;
            armed_q <= 1'b1;
            strb_q  <= 1'b0;
            cnt_q   <= '0;
        end else if (bit_en && armed_q) begin
            strb_q <= (cnt_q == '0);
            cnt_q  <= (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    assign evt = (kind == KIND_STROBE) ? strb_q : irq_q;

    // R6: the interrupt level holds while the receive state lasts
    a_r6_irq_hold: assert property (@(posedge clk) disable iff (rst)
        (irq_q && active) |=> irq_q);

    // R7: a strobe lasts exactly one bit period
    a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
        (strb_q && bit_en && active) |=> !strb_q);

    // R9: leaving the receive state disarms everything
    a_r9_evt_clear: assert property (@(posedge clk) disable iff (rst)
        !active |=> (!irq_q && !strb_q && !armed_q && cnt_q == '0));

    // R10: with no source selected the event line never arms
    a_r10_no_source: assert property (@(posedge clk) disable iff (rst)
        ((src == SRC_NONE) && !armed_q) |=> !armed_q);

endmodule

// File: rtl/rawrx_port.sv
module rawrx_port
    import rawrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       rx_bit,
    input  logic       pre_det,
    input  logic       sync_det,
    input  logic       rx_state,
    input  logic [1:0] data_mode,
    input  logic [7:0] pin_cfg,
    output logic       rx_clk_o,
    output logic       rx_data_o,
    output logic       evt_o
);

    pincfg_t cfg;
    logic    active;

    assign cfg      = decode_pincfg(pin_cfg);
    assign active   = rx_state && mode_is_raw(data_mode);
    assign rx_clk_o = active && bit_en;

    rawrx_data_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .bit_en  (bit_en),
        .rule    (cfg.gate),
        .pre_det (pre_det),
        .rx_bit  (rx_bit),
        .rx_data (rx_data_o)
    );

    rawrx_event_gen #(
        .BITS_PER_BYTE (BYTE_BITS)
    ) u_evt (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .bit_en   (bit_en),
        .pre_det  (pre_det),
        .sync_det (sync_det),
        .src      (cfg.src),
        .kind     (cfg.kind),
        .evt      (evt_o)
    );

    // R2: the host clock only runs inside the receive state
    a_r2_clk_gated: assert property (@(posedge clk) disable iff (rst)
        rx_clk_o |-> (rx_state && bit_en));

    // R1: disabled data modes keep data and event quiet
    a_r1_mode_off: assert property (@(posedge clk) disable iff (rst)
        ((data_mode == 2'd0) || (data_mode == 2'd3)) |=> (!rx_data_o && !evt_o));

    // R11: reset clears the outputs on the next cycle
    a_r11_reset: assert property (@(posedge clk)
        rst |=> (!rx_data_o && !evt_o));

endmodule

// File: tb/tb_rawrx_port.sv
`timescale 1ns/1ps
module tb_rawrx_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b0;
    logic       pre_det = 1'b0;
    logic       sync_det = 1'b0;
    logic       rx_state = 1'b0;
    logic [1:0] data_mode = 2'd0;
    logic [7:0] pin_cfg = 8'h00;
    logic       rx_clk_o, rx_data_o, evt_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rawrx_port dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
        .pre_det(pre_det), .sync_det(sync_det), .rx_state(rx_state),
        .data_mode(data_mode), .pin_cfg(pin_cfg),
        .rx_clk_o(rx_clk_o), .rx_data_o(rx_data_o), .evt_o(evt_o)
    );

    // [20] rx_state [19:18] mode [17:10] code [9] pre [8] sync [7] bit
    // [6] exp clk [5] exp data [4] exp event [3:0] requirement number
    localparam int NV = 44;
    localparam logic [20:0] TBL [0:NV-1] = '{
        // R4/R7: preamble gate, strobe on sync
        {1'b1,2'd1,8'hA5,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0, 4'd4},
        {1'b1,2'd1,8'hA5,1'b1,1'b0,1'b1, 1'b1,1'b1,1'b0, 4'd4},
        {1'b1,2'd1,8'hA5,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd4},
        {1'b1,2'd1,8'hA5,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b0, 4'd7},
        {1'b1,2'd1,8'hA5,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b1, 4'd7},
        {1'b1,2'd1,8'hA5,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd7},
        {1'b1,2'd1,8'hA5,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b0, 4'd7},
        {1'b1,2'd1,8'hA5,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b0, 4'd7},
        {1'b1,2'd1,8'hA5,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd7},
        {1'b1,2'd1,8'hA5,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd7},
        {1'b1,2'd1,8'hA5,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b0, 4'd7},
        {1'b1,2'd1,8'hA5,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b0, 4'd7},
        {1'b1,2'd1,8'hA5,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 4'd7},
        {1'b1,2'd1,8'hA5,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b0, 4'd7},
        // R9: leave and re-enter
        {1'b0,2'd1,8'hA5,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0, 4'd9},
        {1'b1,2'd1,8'hA5,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0, 4'd9},
        {1'b0,2'd1,8'hA5,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd9},
        // R6: interrupt on preamble, mode 2
        {1'b1,2'd2,8'hA1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0, 4'd6},
        {1'b1,2'd2,8'hA1,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1, 4'd6},
        {1'b1,2'd2,8'hA1,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b1, 4'd6},
        {1'b1,2'd2,8'hA1,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1, 4'd6},
        {1'b0,2'd2,8'hA1,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0, 4'd9},
        // R3/R8: immediate gate, strobe on sync, resync mid-byte
        {1'b1,2'd1,8'hA6,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b0, 4'd3},
        {1'b1,2'd1,8'hA6,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd3},
        {1'b1,2'd1,8'hA6,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b0, 4'd7},
        {1'b1,2'd1,8'hA6,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b1, 4'd7},
        {1'b1,2'd1,8'hA6,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd7},
        {1'b1,2'd1,8'hA6,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b0, 4'd8},
        {1'b1,2'd1,8'hA6,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 4'd8},
        {1'b1,2'd1,8'hA6,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b0, 4'd8},
        {1'b0,2'd1,8'hA6,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0, 4'd9},
        // R1: disabled data modes
        {1'b1,2'd0,8'hA6,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0, 4'd1},
        {1'b1,2'd3,8'hA3,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0, 4'd1},
        // R10: unknown code
        {1'b1,2'd1,8'hA9,1'b1,1'b0,1'b1, 1'b1,1'b0,1'b0, 4'd10},
        {1'b1,2'd1,8'hA9,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0, 4'd10},
        {1'b1,2'd1,8'hA9,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0, 4'd10},
        {1'b0,2'd1,8'hA9,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0, 4'd9},
        // R5: strobe on preamble
        {1'b1,2'd1,8'hA2,1'b1,1'b0,1'b1, 1'b1,1'b1,1'b0, 4'd5},
        {1'b1,2'd1,8'hA2,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 4'd5},
        {1'b1,2'd1,8'hA2,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b0, 4'd5},
        {1'b0,2'd1,8'hA2,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0, 4'd9},
        // R5: immediate gate, interrupt on sync
        {1'b1,2'd1,8'hA3,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd5},
        {1'b1,2'd1,8'hA3,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1, 4'd5},
        {1'b1,2'd1,8'hA3,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 4'd6}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary_and_end();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary_and_end();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs low during and after reset
        chk("R11 data at reset", rx_data_o, 1'b0);
        chk("R11 event at reset", evt_o, 1'b0);
        chk("R2 clock at reset", rx_clk_o, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rx_state  = TBL[i][20];
            data_mode = TBL[i][19:18];
            pin_cfg   = TBL[i][17:10];
            pre_det   = TBL[i][9];
            sync_det  = TBL[i][8];
            rx_bit    = TBL[i][7];
            bit_en    = 1'b1;
            #1;
            chk($sformatf("R2 clock step %0d", i), rx_clk_o, TBL[i][6]);
            @(negedge clk);
            bit_en   = 1'b0;
            pre_det  = 1'b0;
            sync_det = 1'b0;
            #1;
            chk($sformatf("R%0d data step %0d", TBL[i][3:0], i), rx_data_o, TBL[i][5]);
            chk($sformatf("R%0d event step %0d", TBL[i][3:0], i), evt_o, TBL[i][4]);
            chk("R2 clock idle", rx_clk_o, 1'b0);
        end

        // R6: interrupt holds across idle cycles with no bit enable
        repeat (3) @(negedge clk);
        chk("R6 interrupt held idle", evt_o, 1'b1);

        // R11: mid-run reset while the interrupt is raised
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 event after reset", evt_o, 1'b0);
        chk("R11 data after reset", rx_data_o, 1'b0);

        summary_and_end();
    end

endmodule